// File: doc/BRIEF.md
# Symmetric-Subset Voting Step Detector

Given the full truth table of a positive switching function of `NVAR` variables, and a mask naming a subset Y of variables already known to be mutually symmetric, the block decides whether Y can be pulled out as the inputs of a single voting gate. A voting gate over |Y| inputs outputs 1 when at least t of those inputs are 1.

For each count j from 0 to |Y|, the block tallies the true minterms whose values on Y match one fixed assignment carrying exactly j ones. These tallies are the weights w_j. The subset feeds one voting gate exactly when the weights take one value below some position t and a different single value from t upward. When that holds, the block reports t. Otherwise it reports failure.

Each job starts with a one-cycle `start` pulse. The block then reads one minterm per clock and ends with a one-cycle `done` pulse.

Top module: `sym_step_detect`

## Requirements
- R1: After reset, `done`, `found` and `fail` are 0 and `step_t` is 0.
- R2: Variable k is bit k of the truth-table index, and `truth[i]` is the function value at index i. The fixed assignment with j ones sets the j members of Y with the lowest bit positions to 1 and the other members to 0. w_j counts the indices i with `truth[i]`=1 whose bits in Y equal that assignment.
- R3: If some t in 1..|Y| gives w_j = w_0 for every j < t, and w_j = w_t ≠ w_0 for every t ≤ j ≤ |Y|, the block raises `found` and `step_t` equals t.
- R4: A weight sequence with more than two distinct values, or with two steps, raises `fail` (for example 0,1,3,4).
- R5: A constant weight sequence raises `fail`.
- R6: A mask with fewer than two set bits raises `done` and `fail` at the same clock edge that samples `start`.
- R7: For a mask with at least two bits, `done` is a one-cycle pulse at the 2^NVAR+1-th edge after the edge that samples `start`. `found`, `fail` and `step_t` keep their values until the next accepted `start`.
- R8: A `start` pulse while a job is in progress is ignored: it produces no extra `done` and does not alter the running job's result.
- R9: When `done` is high, exactly one of `found` and `fail` is high, and `step_t` is 0 whenever `fail` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin a job; truth table and mask are captured |
| truth | input | 2^NVAR | Truth table, bit i is the function value at index i |
| ymask | input | NVAR | Members of the symmetric subset Y |
| done | output | 1 | One-cycle result pulse |
| found | output | 1 | Single two-level step detected |
| fail | output | 1 | No single step, or mask too small |
| step_t | output | clog2(NVAR+1) | Threshold t of the voting gate when found |

## Verification
The hardest case to reach is one where the canonical ordering decides the answer. If Y is symmetric, every assignment with j ones gives the same tally, so an ordering error hides. The stimulus therefore includes a mask with a gap between its members and a function that depends on only one of them. Choosing the lowest member then gives a step at t=1, and choosing any other member moves the step to t=2. A second subtle case is a start pulse sent mid-scan with a different mask: the scoreboard expects only the first job's result, at the first job's latency.

// File: rtl/sym_step_detect.sv
module sym_step_detect #(
  parameter int NVAR = 5
) (
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic                           start,
  input  logic [(1<<NVAR)-1:0]           truth,
  input  logic [NVAR-1:0]                ymask,
  output logic                           done,
  output logic                           found,
  output logic                           fail,
  output logic [$clog2(NVAR+1)-1:0]      step_t
);
  localparam int NT = 1 << NVAR;
  localparam int TW = $clog2(NVAR+1);
  localparam int CW = NVAR + 1;

  typedef enum logic [1:0] {S_IDLE, S_SCAN, S_EVAL} state_t;

  state_t          st;
  logic [NT-1:0]   tt;
  logic [NVAR-1:0] mk;
  logic [NVAR-1:0] idx;
  logic [CW-1:0]   wcnt [NVAR+1];

  function automatic logic [TW-1:0] popcnt(input logic [NVAR-1:0] v);
    logic [TW-1:0] c;
    c = '0;
    for (int k = 0; k < NVAR; k++) c = c + TW'(v[k]);
    return c;
  endfunction

  logic [NVAR-1:0] on_y, off_y, low_off;
  logic            canon;
  logic [TW-1:0]   jcur, ny;
  logic            bad_mask;

  assign on_y     = idx & mk;
  assign off_y    = mk & ~idx;
  assign low_off  = off_y & (~off_y + 1'b1);
  assign canon    = (on_y & ~(low_off - 1'b1)) == '0;
  assign jcur     = popcnt(on_y);
  assign ny       = popcnt(mk);
  assign bad_mask = popcnt(ymask) < TW'(2);

  logic          ev_found, stepped, ok;
  logic [TW-1:0] ev_t;
  logic [CW-1:0] lvl;

  always_comb begin
    stepped = 1'b0;
    ok      = 1'b1;
    ev_t    = '0;
    lvl     = wcnt[0];
    for (int j = 1; j <= NVAR; j++) begin
      if (TW'(j) <= ny) begin
        if (!stepped) begin
          if (wcnt[j] != wcnt[0]) begin
            stepped = 1'b1;
            ev_t    = TW'(j);
            lvl     = wcnt[j];
          end
        end else if (wcnt[j] != lvl) begin
          ok = 1'b0;
        end
      end
    end
    ev_found = stepped && ok;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st     <= S_IDLE;
      tt     <= '0;
      mk     <= '0;
      idx    <= '0;
      done   <= 1'b0;
      found  <= 1'b0;
      fail   <= 1'b0;
      step_t <= '0;
      for (int j = 0; j <= NVAR; j++) wcnt[j] <= '0;
    end else begin
      done <= 1'b0;
      case (st)
        S_IDLE: if (start) begin
          tt     <= truth;
          mk     <= ymask;
          found  <= 1'b0;
          fail   <= 1'b0;
          step_t <= '0;
          if (bad_mask) begin
            done <= 1'b1;
            fail <= 1'b1;
          end else begin
            st  <= S_SCAN;
            idx <= '0;
            for (int j = 0; j <= NVAR; j++) wcnt[j] <= '0;
          end
        end
        S_SCAN: begin
          if (tt[idx] && canon) wcnt[jcur] <= wcnt[jcur] + 1'b1;
          idx <= idx + 1'b1;
          if (idx == NVAR'(NT-1)) st <= S_EVAL;
        end
        S_EVAL: begin
          done   <= 1'b1;
          found  <= ev_found;
          fail   <= !ev_found;
          step_t <= ev_found ? ev_t : '0;
          st     <= S_IDLE;
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  p_bad_mask_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_IDLE && start && bad_mask) |=> (done && fail && !found));

  p_done_pulse_r7: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  p_exclusive_r9: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (found != fail));

  p_fail_zero_t_r9: assert property (@(posedge clk) disable iff (!rst_n)
    fail |-> (step_t == '0));

  p_t_range_r3: assert property (@(posedge clk) disable iff (!rst_n)
    found |-> (step_t >= TW'(1) && step_t <= ny));

  p_busy_ignore_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_SCAN && start) |=> (st != S_IDLE && !done));

  p_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_IDLE && !start) |=> ($stable(found) && $stable(fail) && $stable(step_t)));
endmodule

// File: tb/test_sym_step_detect.sv
module test_sym_step_detect;
  localparam int NVAR = 5;
  localparam int NT = 1 << NVAR;
  localparam int TW = $clog2(NVAR+1);
  localparam time CLK_PERIOD = 10ns;

  logic clk = 1'b0, rst_n = 1'b0, start = 1'b0;
  logic [NT-1:0] truth = '0;
  logic [NVAR-1:0] ymask = '0;
  logic done, found, fail;
  logic [TW-1:0] step_t;

  always #(CLK_PERIOD/2) clk = ~clk;

  sym_step_detect #(.NVAR(NVAR)) i_sym_step_detect (
    .clk(clk), .rst_n(rst_n), .start(start), .truth(truth), .ymask(ymask),
    .done(done), .found(found), .fail(fail), .step_t(step_t));

  int checks = 0, errors = 0, cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  int q_found[$], q_t[$], q_lat[$], q_cyc[$];
  string q_tag[$];

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic logic [NT-1:0] make_tt(input int id);
    logic [NT-1:0] r;
    for (int i = 0; i < NT; i++) begin
      int s3, s4, s5;
      s3 = i[0] + i[1] + i[2];
      s4 = s3 + i[3];
      s5 = s4 + i[4];
      case (id)
        0: r[i] = s3 >= 2;
        1: r[i] = s3 == 3;
        2: r[i] = s3 >= 1;
        3: r[i] = s5 >= 3;
        4: r[i] = 1'b0;
        5: r[i] = 1'b1;
        6: r[i] = i[1];
        7: r[i] = i[0] | (i[1] & i[3]);
        8: r[i] = (s3 >= 2) & (i[3] | i[4]);
        default: r[i] = s4 >= 2;
      endcase
    end
    return r;
  endfunction

  task automatic expect_of(input logic [NT-1:0] t, input logic [NVAR-1:0] m,
                           output int ef, output int et);
    int ny, w[NVAR+1], lvl;
    bit stepped, ok;
    ny = 0;
    for (int k = 0; k < NVAR; k++) ny += m[k];
    ef = 0; et = 0;
    if (ny < 2) return;
    for (int j = 0; j <= ny; j++) begin
      int a, rank;
      a = 0; rank = 0;
      for (int k = 0; k < NVAR; k++)
        if (m[k]) begin
          if (rank < j) a |= (1 << k);
          rank++;
        end
      w[j] = 0;
      for (int i = 0; i < NT; i++) if ((i & m) == a && t[i]) w[j]++;
    end
    stepped = 0; ok = 1; lvl = w[0];
    for (int j = 1; j <= ny; j++)
      if (!stepped) begin
        if (w[j] != w[0]) begin stepped = 1; et = j; lvl = w[j]; end
      end else if (w[j] != lvl) ok = 0;
    ef = (stepped && ok) ? 1 : 0;
    if (!ef) et = 0;
  endtask

  task automatic run(input int id, input logic [NVAR-1:0] m, input string tag, input bit poke);
    int ef, et, ny;
    logic [NT-1:0] t;
    t = make_tt(id);
    expect_of(t, m, ef, et);
    ny = 0;
    for (int k = 0; k < NVAR; k++) ny += m[k];
    q_found.push_back(ef); q_t.push_back(et); q_tag.push_back(tag);
    q_lat.push_back(ny < 2 ? 1 : NT + 2);
    @(negedge clk);
    truth = t; ymask = m; start = 1'b1;
    q_cyc.push_back(cyc);
    @(negedge clk);
    start = 1'b0;
    if (poke) begin
      repeat (4) @(negedge clk);
      truth = ~t; ymask = 5'b00011; start = 1'b1;
      @(negedge clk);
      start = 1'b0;
    end
    while (q_found.size() != 0) @(negedge clk);
    repeat (2) @(negedge clk);
  endtask

  initial begin
    forever begin
      @(negedge clk);
      if (done) begin
        if (q_found.size() == 0) begin
          check(0, "R8 unexpected done", 1, 0);
        end else begin
          int ef, et, el, c0;
          string tg;
          ef = q_found.pop_front(); et = q_t.pop_front(); el = q_lat.pop_front();
          c0 = q_cyc.pop_front(); tg = q_tag.pop_front();
          check(found == ef, {tg, " found"}, found, ef);
          check(fail == !ef, {tg, " fail R9"}, fail, !ef);
          check(int'(step_t) == et, {tg, " step_t"}, step_t, et);
          check(cyc - c0 == el, "R7 latency", cyc - c0, el);
        end
      end
    end
  end

  bit finished = 0;
  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      check(0, "watchdog", 0, 1);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    check(!done && !found && !fail && step_t == 0, "R1 reset outputs", {done, found, fail}, 0);
    rst_n = 1'b1;
    run(0, 5'b00111, "R3 majority t=2", 0);
    run(1, 5'b00111, "R3 and t=3", 0);
    run(2, 5'b00111, "R3 or t=1", 0);
    run(8, 5'b00111, "R3 composed t=2", 0);
    run(9, 5'b01111, "R3 four-input t=2", 0);
    run(7, 5'b01010, "R3 gapped mask t=2", 0);
    run(6, 5'b01010, "R2 lowest member ordering", 0);
    run(3, 5'b00111, "R4 multi-level", 0);
    run(4, 5'b00111, "R5 constant zero", 0);
    run(5, 5'b00111, "R5 constant one", 0);
    run(0, 5'b00100, "R6 single-bit mask", 0);
    run(0, 5'b00000, "R6 empty mask", 0);
    run(1, 5'b00111, "R8 busy start", 1);
    run(0, 5'b00111, "R7 before hold", 0);
    repeat (5) @(negedge clk);
    check(found && !fail && step_t == 2, "R7 hold after done", step_t, 2);
    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule